// File: doc/BRIEF.md
# Multi-Queue FIFO with Almost-Empty Flag

This block stores words for sixteen independent first-in first-out queues in one shared array. A write port on its own clock puts each word into the queue that the write address names. A read port on a second clock serves one queue at a time. The read side picks that queue by presenting an address while the select strobe is high.

Data is presented in first-word-fall-through fashion. The head word of the selected queue sits on the output without a read strobe, and a read strobe moves on to the next word. An active-low almost-empty flag shows the fill level of the selected queue against a fixed offset. Several of these blocks can share one output bus. The upper bits of each address name a device. A block whose device is not the one selected releases its data and flag outputs to high impedance, so that the selected device alone drives the bus.

Word counts cross between clock domains as Gray-coded pointers through two-flop synchronizers. The read domain therefore sees new writes a fixed number of read-clock edges late. It sees its own reads one edge late, which gives the flag a slow-to-clear and quick-to-set character.

Top module: `mqf_multiq`

## Requirements
- R1: After reset, device 0 has queue 0 selected, and with DEVICE_ID 0 it drives `q_out` to 0 and `ae_n` to 0.
- R2: A write is accepted on a `wclk` edge with `wr_en` high. `wr_addr[5:4]` must equal DEVICE_ID, and `wr_addr[3:0]` selects the queue. Writes that name another device change nothing in this block.
- R3: Every queue returns its words in the order written, independent of traffic to other queues.
- R4: `sel_en` high on `rclk` edge k selects queue `sel_addr[3:0]` of device `sel_addr[5:4]`. From edge k+1 the head word of that queue is on `q_out`, and a `rd_en` sampled at edge k+1 is ignored.
- R5: `rd_en` high at an `rclk` edge, outside the cycle after a selection and with the selected queue non-empty, consumes the head word. The next word is on `q_out` right after that edge.
- R6: A read of an empty queue moves no pointer and leaves `q_out` unchanged. The next word written to that queue is the next word presented.
- R7: `ae_n` is 0 while the selected queue holds OFFSET (default 8) words or fewer, and 1 otherwise. After a read at edge e that brings the count down to OFFSET, `ae_n` is still 1 after edge e+1 and is 0 after edge e+2.
- R8: A write at a `wclk` edge that lifts the count above OFFSET raises `ae_n` on the third `rclk` edge after that write edge. This holds when the write edge comes at least setup time before the next `rclk` edge.
- R9: On a selection at edge k, `ae_n` shows the newly selected queue's level from edge k+1.
- R10: A selection at edge k that names another device puts `q_out` and `ae_n` into high impedance from edge k+1. Selecting a queue of this device drives them again from the edge after that selection.
- R11: A queue holds at most DEPTH (default 16) words, and a write to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Device number [5:4] and queue number [3:0] for the write |
| wr_data | input | 18 | Word to store |
| rclk | input | 1 | Read clock |
| sel_en | input | 1 | Queue-select strobe for the read side |
| sel_addr | input | 6 | Device number [5:4] and queue number [3:0] to select |
| rd_en | input | 1 | Read strobe; consumes the presented word |
| q_out | output | 18 | Head word of the selected queue; high impedance when another device is selected |
| ae_n | output | 1 | Almost-empty flag, active low; high impedance when another device is selected |

## Verification
The hardest case to reach is two devices sharing one output bus. With a single device there is only a floating bus to observe. The bench therefore places a second device with a different device number on the same data and flag wires and loads the same queue number in both with different words. It then switches the selection back and forth, and the value seen on the bus shows which device drives it and that the other has let go. The asymmetric flag latencies are reached by filling a queue to exactly one word above the offset and then reading one word. A single word is then written into a queue sitting exactly at the offset. The write and read clocks run at a fixed phase offset, so the edge counts are deterministic.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  localparam int unsigned GW = 16;

  function automatic logic [GW-1:0] bin_to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray_to_bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/mqf_rst_sync.sv
module mqf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/mqf_gray_sync.sv
module mqf_gray_sync
  import mqf_pkg::*;
#(
  parameter int unsigned NQ = 16,
  parameter int unsigned W  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in [NQ],
  output logic [W-1:0] bin_out [NQ]
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= '0;
        s2_q <= '0;
      end else begin
        s1_q <= gray_in[g];
        s2_q <= s1_q;
      end
    end

    assign bin_out[g] = W'(gray_to_bin(GW'(s2_q)));
  end
endmodule

// File: rtl/mqf_wr_port.sv
module mqf_wr_port
  import mqf_pkg::*;
#(
  parameter int unsigned NQ        = 16,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DEVW      = 2,
  parameter int unsigned DEVICE_ID = 0,
  localparam int unsigned QAW      = $clog2(NQ),
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned PW       = AW + 1,
  localparam int unsigned AT       = QAW + DEVW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AT-1:0]     wr_addr,
  input  logic [PW-1:0]     rptr_bin  [NQ],
  output logic [PW-1:0]     wptr_gray [NQ],
  output logic              mem_we,
  output logic [QAW+AW-1:0] mem_wa,
  output logic [PW-1:0]     wfill
);
  logic [PW-1:0]  wptr_q [NQ];
  logic [PW-1:0]  wptr_d [NQ];
  logic [PW-1:0]  wgray_q [NQ];
  logic [PW-1:0]  wgray_d [NQ];
  logic [QAW-1:0] tq;
  logic           mine;
  logic           accept;

  always_comb begin
    tq     = wr_addr[QAW-1:0];
    mine   = (wr_addr[AT-1:QAW] == DEVW'(DEVICE_ID));
    wfill  = wptr_q[tq] - rptr_bin[tq];
    accept = wr_en && mine && (wfill != PW'(DEPTH));
    for (int i = 0; i < NQ; i++) begin
      wptr_d[i] = wptr_q[i];
    end
    if (accept) begin
      wptr_d[tq] = wptr_q[tq] + PW'(1);
    end
    for (int i = 0; i < NQ; i++) begin
      wgray_d[i] = PW'(bin_to_gray(GW'(wptr_d[i])));
    end
    mem_we = accept;
    mem_wa = {tq, wptr_q[tq][AW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        wptr_q[i]  <= '0;
        wgray_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        wptr_q[i]  <= wptr_d[i];
        wgray_q[i] <= wgray_d[i];
      end
    end
  end

  assign wptr_gray = wgray_q;
endmodule

// File: rtl/mqf_rd_port.sv
module mqf_rd_port
  import mqf_pkg::*;
#(
  parameter int unsigned NQ        = 16,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DW        = 18,
  parameter int unsigned DEVW      = 2,
  parameter int unsigned DEVICE_ID = 0,
  parameter int unsigned OFFSET    = 8,
  localparam int unsigned QAW      = $clog2(NQ),
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned PW       = AW + 1,
  localparam int unsigned AT       = QAW + DEVW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_en,
  input  logic [AT-1:0]     sel_addr,
  input  logic              rd_en,
  input  logic [PW-1:0]     wptr_bin  [NQ],
  input  logic [DW-1:0]     head_data,
  output logic [PW-1:0]     rptr_gray [NQ],
  output logic [QAW+AW-1:0] head_addr,
  output logic [DW-1:0]     dat_q,
  output logic              ae_q,
  output logic              oe_q,
  output logic              rd_fire,
  output logic [PW-1:0]     sel_cnt
);
  logic [QAW-1:0] sel_q, sel_d;
  logic           mine_q, mine_d;
  logic           busy_q, busy_d;
  logic [PW-1:0]  rptr_q [NQ];
  logic [PW-1:0]  rptr_d [NQ];
  logic [PW-1:0]  rlag_q [NQ];
  logic [PW-1:0]  rgray_q [NQ];
  logic [PW-1:0]  rgray_d [NQ];
  logic [PW-1:0]  cnt_after;
  logic [PW-1:0]  cnt_lag;
  logic [DW-1:0]  dat_d;
  logic           ae_d;
  logic           oe_d;

  always_comb begin
    sel_d   = sel_en ? sel_addr[QAW-1:0] : sel_q;
    mine_d  = sel_en ? (sel_addr[AT-1:QAW] == DEVW'(DEVICE_ID)) : mine_q;
    busy_d  = sel_en;
    sel_cnt = wptr_bin[sel_q] - rptr_q[sel_q];
    rd_fire = rd_en && !busy_q && mine_q && (sel_cnt != '0);
    for (int i = 0; i < NQ; i++) begin
      rptr_d[i] = rptr_q[i];
    end
    if (rd_fire) begin
      rptr_d[sel_q] = rptr_q[sel_q] + PW'(1);
    end
    for (int i = 0; i < NQ; i++) begin
      rgray_d[i] = PW'(bin_to_gray(GW'(rptr_d[i])));
    end
    cnt_after = wptr_bin[sel_q] - rptr_d[sel_q];
    head_addr = {sel_q, rptr_d[sel_q][AW-1:0]};
    dat_d     = (cnt_after != '0) ? head_data : dat_q;
    cnt_lag   = wptr_bin[sel_q] - rlag_q[sel_q];
    ae_d      = (cnt_lag > PW'(OFFSET));
    oe_d      = mine_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mine_q <= (DEVICE_ID == 0);
      busy_q <= 1'b0;
      dat_q  <= '0;
      ae_q   <= 1'b0;
      oe_q   <= (DEVICE_ID == 0);
      for (int i = 0; i < NQ; i++) begin
        rptr_q[i]  <= '0;
        rlag_q[i]  <= '0;
        rgray_q[i] <= '0;
      end
    end else begin
      sel_q  <= sel_d;
      mine_q <= mine_d;
      busy_q <= busy_d;
      dat_q  <= dat_d;
      ae_q   <= ae_d;
      oe_q   <= oe_d;
      for (int i = 0; i < NQ; i++) begin
        rptr_q[i]  <= rptr_d[i];
        rlag_q[i]  <= rptr_q[i];
        rgray_q[i] <= rgray_d[i];
      end
    end
  end

  assign rptr_gray = rgray_q;
endmodule

// File: rtl/mqf_multiq.sv
module mqf_multiq #(
  parameter int unsigned NQ        = 16,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DW        = 18,
  parameter int unsigned DEVW      = 2,
  parameter int unsigned DEVICE_ID = 0,
  parameter int unsigned OFFSET    = 8,
  localparam int unsigned QAW      = $clog2(NQ),
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned PW       = AW + 1,
  localparam int unsigned AT       = QAW + DEVW
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [AT-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          sel_en,
  input  logic [AT-1:0] sel_addr,
  input  logic          rd_en,
  output logic [DW-1:0] q_out,
  output logic          ae_n
);
  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wptr_gray  [NQ];
  logic [PW-1:0]     rptr_gray  [NQ];
  logic [PW-1:0]     wptr_rsync [NQ];
  logic [PW-1:0]     rptr_wsync [NQ];
  logic              mem_we;
  logic [QAW+AW-1:0] mem_wa;
  logic [QAW+AW-1:0] head_addr;
  logic [DW-1:0]     head_data;
  logic [DW-1:0]     dat_q;
  logic              ae_q, oe_q, rd_fire;
  logic [PW-1:0]     sel_cnt, wfill;
  logic [DW-1:0]     mem [NQ*DEPTH];

  mqf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  mqf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  mqf_wr_port #(
    .NQ(NQ), .DEPTH(DEPTH), .DEVW(DEVW), .DEVICE_ID(DEVICE_ID)
  ) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rptr_bin(rptr_wsync), .wptr_gray(wptr_gray),
    .mem_we(mem_we), .mem_wa(mem_wa), .wfill(wfill)
  );

  mqf_gray_sync #(.NQ(NQ), .W(PW)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wptr_gray), .bin_out(wptr_rsync)
  );

  mqf_gray_sync #(.NQ(NQ), .W(PW)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rptr_gray), .bin_out(rptr_wsync)
  );

  always_ff @(posedge wclk) begin
    if (mem_we) mem[mem_wa] <= wr_data;
  end

  assign head_data = mem[head_addr];

  mqf_rd_port #(
    .NQ(NQ), .DEPTH(DEPTH), .DW(DW), .DEVW(DEVW),
    .DEVICE_ID(DEVICE_ID), .OFFSET(OFFSET)
  ) u_rd (
    .clk(rclk), .rst_n(rrst_n), .sel_en(sel_en), .sel_addr(sel_addr),
    .rd_en(rd_en), .wptr_bin(wptr_rsync), .head_data(head_data),
    .rptr_gray(rptr_gray), .head_addr(head_addr), .dat_q(dat_q),
    .ae_q(ae_q), .oe_q(oe_q), .rd_fire(rd_fire), .sel_cnt(sel_cnt)
  );

  assign q_out = oe_q ? dat_q : {DW{1'bz}};
  assign ae_n  = oe_q ? ae_q  : 1'bz;
endmodule

// File: rtl/mqf_multiq_chk.sv
module mqf_multiq_chk #(
  parameter int unsigned AT        = 6,
  parameter int unsigned QAW       = 4,
  parameter int unsigned DEVW      = 2,
  parameter int unsigned PW        = 5,
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DEVICE_ID = 0
) (
  input logic          rclk,
  input logic          wclk,
  input logic          rrst_n,
  input logic          wrst_n,
  input logic          sel_en,
  input logic [AT-1:0] sel_addr,
  input logic          rd_fire,
  input logic          oe_q,
  input logic [PW-1:0] sel_cnt,
  input logic [PW-1:0] wfill
);
  a_r4_no_read_after_select: assert property (
    @(posedge rclk) disable iff (!rrst_n)
      sel_en |=> !rd_fire
  );

  // R10: choosing another device releases the outputs one edge later
  a_r10_foreign_release: assert property (
    @(posedge rclk) disable iff (!rrst_n)
      (sel_en && (sel_addr[AT-1:QAW] != DEVW'(DEVICE_ID))) |=> ##1 !oe_q
  );

  a_r10_drive_steady: assert property (
    @(posedge rclk) disable iff (!rrst_n)
      !sel_en |=> ##1 $stable(oe_q)
  );

  a_r11_no_overflow: assert property (
    @(posedge wclk) disable iff (!wrst_n)
      wfill <= PW'(DEPTH)
  );

  a_r7_count_bound: assert property (
    @(posedge rclk) disable iff (!rrst_n)
      sel_cnt <= PW'(DEPTH)
  );
endmodule

bind mqf_multiq mqf_multiq_chk #(
  .AT(AT), .QAW(QAW), .DEVW(DEVW), .PW(PW), .DEPTH(DEPTH), .DEVICE_ID(DEVICE_ID)
) u_chk (
  .rclk(rclk), .wclk(wclk), .rrst_n(rrst_n), .wrst_n(wrst_n),
  .sel_en(sel_en), .sel_addr(sel_addr), .rd_fire(rd_fire),
  .oe_q(oe_q), .sel_cnt(sel_cnt), .wfill(wfill)
);

// File: tb/tb_mqf_multiq.sv
`timescale 1ns/1ps
module tb_mqf_multiq;
  localparam int OFF = 8;
  localparam int VN  = 4;
  localparam logic [3:0]  VQ    [VN] = '{4'd3, 4'd12, 4'd0, 4'd15};
  localparam int          VCNT  [VN] = '{5, 10, 9, 8};
  localparam logic [17:0] VBASE [VN] = '{18'h100, 18'h200, 18'h300, 18'h3A0};

  logic        rclk = 1'b0;
  logic        wclk = 1'b1;
  logic        rst_n, wr_en, sel_en, rd_en;
  logic [5:0]  wr_addr, sel_addr;
  logic [17:0] wr_data;
  wire  [17:0] q_bus;
  wire         ae_bus;
  int          checks = 0;
  int          errs   = 0;
  bit          done   = 1'b0;

  always #2 rclk = ~rclk;
  always #2 wclk = ~wclk;

  mqf_multiq #(.DEVICE_ID(0)) dut (
    .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rclk(rclk), .sel_en(sel_en), .sel_addr(sel_addr), .rd_en(rd_en),
    .q_out(q_bus), .ae_n(ae_bus)
  );

  mqf_multiq #(.DEVICE_ID(1)) dut_peer (
    .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rclk(rclk), .sel_en(sel_en), .sel_addr(sel_addr), .rd_en(rd_en),
    .q_out(q_bus), .ae_n(ae_bus)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rtick(input int n);
    repeat (n) begin @(posedge rclk); #1; end
  endtask

  task automatic push(input logic [5:0] a, input logic [17:0] d);
    @(posedge wclk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge wclk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pick(input logic [5:0] a);
    @(posedge rclk); #1;
    sel_en = 1'b1; sel_addr = a;
    @(posedge rclk); #1;
    sel_en = 1'b0;
    @(posedge rclk); #1;
  endtask

  task automatic pop();
    @(posedge rclk); #1;
    rd_en = 1'b1;
    @(posedge rclk); #1;
    rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; sel_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; sel_addr = '0; wr_data = '0;
    rtick(5);
    rst_n = 1'b1;
    rtick(5);

    // R1 reset state
    chk("R1 ae_n after reset", ae_bus, 0);
    chk("R1 q_out after reset", q_bus, 0);

    // Table: R3/R5 order and R7 level for several queues
    for (int v = 0; v < VN; v++) begin
      for (int i = 0; i < VCNT[v]; i++) push({2'b00, VQ[v]}, VBASE[v] + 18'(i));
      rtick(4);
      pick({2'b00, VQ[v]});
      chk("R7 level after fill", ae_bus, (VCNT[v] > OFF) ? 1 : 0);
      for (int i = 0; i < VCNT[v]; i++) begin
        chk("R3 R5 fall-through order", q_bus, VBASE[v] + 18'(i));
        pop();
      end
      rtick(3);
      chk("R7 drained", ae_bus, 0);
    end

    // R2 / R10: same queue number in both devices
    push({2'b01, 4'd5}, 18'h155);
    push({2'b00, 4'd5}, 18'h0A5);
    rtick(4);
    pick({2'b00, 4'd5});
    chk("R2 own device word only", q_bus, 18'h0A5);
    pick({2'b01, 4'd5});
    chk("R10 peer drives bus", q_bus, 18'h155);
    pick({2'b00, 4'd5});
    chk("R10 drive returns", q_bus, 18'h0A5);

    // R4: read strobe in cycle after selection is ignored
    push({2'b00, 4'd7}, 18'h07A);
    push({2'b00, 4'd7}, 18'h07B);
    rtick(4);
    @(posedge rclk); #1; sel_en = 1'b1; sel_addr = {2'b00, 4'd7};
    @(posedge rclk); #1; sel_en = 1'b0; rd_en = 1'b1;
    @(posedge rclk); #1; rd_en = 1'b0;
    chk("R4 head after select", q_bus, 18'h07A);
    rtick(1);
    chk("R4 read ignored", q_bus, 18'h07A);
    pop();
    chk("R5 next word", q_bus, 18'h07B);

    // R6: empty read ignored
    pop();
    chk("R6 last word held", q_bus, 18'h07B);
    pop();
    chk("R6 empty read holds", q_bus, 18'h07B);
    push({2'b00, 4'd7}, 18'h07C);
    rtick(4);
    chk("R6 next written word", q_bus, 18'h07C);

    // R7 assert latency
    for (int i = 0; i < 9; i++) push({2'b00, 4'd9}, 18'h900 + 18'(i));
    rtick(4);
    pick({2'b00, 4'd9});
    chk("R7 above offset", ae_bus, 1);
    pop();
    chk("R7 edge e", ae_bus, 1);
    rtick(1);
    chk("R7 edge e+1", ae_bus, 1);
    rtick(1);
    chk("R7 edge e+2", ae_bus, 0);

    // R8 deassert latency
    push({2'b00, 4'd9}, 18'h9FF);
    rtick(1);
    rtick(1);
    chk("R8 edge 2", ae_bus, 0);
    rtick(1);
    chk("R8 edge 3", ae_bus, 1);

    // R9 flag follows selection
    pick({2'b00, 4'd11});
    chk("R9 empty queue selected", ae_bus, 0);
    pick({2'b00, 4'd9});
    chk("R9 back to busy queue", ae_bus, 1);
    chk("R9 head of queue 9", q_bus, 18'h901);

    // R11 full queue drops extra write
    for (int i = 0; i < 17; i++) push({2'b00, 4'd13}, 18'hD00 + 18'(i));
    rtick(4);
    pick({2'b00, 4'd13});
    for (int i = 0; i < 16; i++) begin
      chk("R11 stored word", q_bus, 18'hD00 + 18'(i));
      pop();
    end
    push({2'b00, 4'd13}, 18'hDEE);
    rtick(4);
    chk("R11 extra word dropped", q_bus, 18'hDEE);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule